// File: doc/BRIEF.md
# Fast/Slow Channel Frame Sequencer

This block produces the channel order for a fixed multiplexed acquisition frame that interleaves four fast analog inputs with twenty-five slow ones. The frame is a grid of 6 rows by 9 columns, giving 54 slots, walked row by row. Every row opens with the four fast inputs, so each fast input is visited six times per frame at evenly spaced points. The five trailing columns of all rows together form 30 tail slots. Twenty-five of them carry the slow inputs once each. The last five carry two marker bytes and three bytes of a running frame number.

A timing controller pulses `tick_i` once per sample period, for example at 360 k slots per second, which gives each fast input about 40 ksps and each slow input about 6.6 ksps. The sequencer advances one slot per pulse. For the current slot it presents a slot kind, a channel index, a data byte for marker and count slots, and the enable and address lines of two 16-input analog multiplexers. Channels are numbered 0 to 28: 0 to 3 are fast and 4 to 28 are slow.

Top module: `fsq_frame_seq`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the current slot is row 0, column 0. The slot is kind 0 (fast) on channel 0, the frame count is 0, mux A is enabled with address 0, and mux B is disabled.
- R2: Each clock edge with `tick_i` high moves to the next slot in row-major order: 9 columns per row and 6 rows, then back to row 0, column 0 after slot 53. With `tick_i` low, every output holds.
- R3: Columns 0 to 3 of every row are kind 0 (fast), and `chan_o` equals the column number.
- R4: A slot in column 4 to 8 has tail number t = 5*row + column - 4. For t from 0 to 24 the slot is kind 1 (slow) on channel 4+t, so the slow channels appear once per frame in ascending order.
- R5: Tail 25 and tail 26 are kind 2 (marker). In them `data_o` is MARK0 (default 0xEB) and then MARK1 (default 0x90).
- R6: Tails 27, 28 and 29 are kind 3 (count). In them `data_o` carries frame-count bits 23:16, then 15:8, then 7:0, zero-extended from CNT_W bits.
- R7: In a fast or slow slot, a channel from 0 to 15 enables mux A with address equal to the channel. A channel from 16 to 28 enables mux B with address equal to the channel minus 16. Exactly one mux is enabled.
- R8: In marker and count slots both muxes are disabled and `chan_o` is 0. In fast and slow slots `data_o` is 0.
- R9: The frame count increases by one on the tick that leaves slot 53. From 2^CNT_W-1 it wraps to 0.
- R10: The frame count changes only on that tick, so all three count bytes of a frame show the same frame number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Advance one slot |
| kind_o | output | 2 | Slot kind: 0 fast, 1 slow, 2 marker, 3 count |
| chan_o | output | 5 | Channel index of a sample slot |
| row_o | output | 3 | Current row |
| col_o | output | 4 | Current column |
| data_o | output | 8 | Marker or count byte |
| sw_a_en_o | output | 1 | Mux A enable |
| sw_a_sel_o | output | 4 | Mux A address |
| sw_b_en_o | output | 1 | Mux B enable |
| sw_b_sel_o | output | 4 | Mux B address |
| frame_cnt_o | output | 24 | Frame number |

## Verification
The bench aims at the boundary between mux A and mux B at channels 15 and 16. A design with an off-by-one split there would enable the wrong multiplexer or present an address of 0 or 16. It covers the change from the last slow slot to the marker slots, where a design that miscounts tail numbers would shift a slow channel into a marker slot or leave a mux enabled during it. It compares the count bytes of several frames, and on a 2-bit counter copy checks the wrap to zero: a wrong byte order or a count changing mid-frame would show up as mismatched bytes. It also checks that outputs hold with no tick and that an asynchronous reset in the middle of a frame returns the design to slot 0.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic [1:0] {
    SLOT_FAST  = 2'd0,
    SLOT_SLOW  = 2'd1,
    SLOT_MARK  = 2'd2,
    SLOT_COUNT = 2'd3
  } slot_kind_e;
endpackage

// File: rtl/fsq_slot_ctr.sv
module fsq_slot_ctr #(
  parameter int unsigned ROWS   = 6,
  parameter int unsigned COLS   = 9,
  parameter int unsigned N_FAST = 4,
  parameter int unsigned ROW_W  = $clog2(ROWS),
  parameter int unsigned COL_W  = $clog2(COLS),
  parameter int unsigned TAIL_W = $clog2(ROWS * (COLS - N_FAST))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [TAIL_W-1:0] tail_o,
  output logic              last_o
);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS - 1);
  localparam logic [COL_W-1:0]  TAIL_COL  = COL_W'(N_FAST);
  localparam logic [TAIL_W-1:0] TAIL_LAST = TAIL_W'(ROWS * (COLS - N_FAST) - 1);

  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [TAIL_W-1:0] tail_q;

  assign last_o = (row_q == ROW_LAST) && (col_q == COL_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      tail_q <= '0;
    end else if (tick_i) begin
      if (col_q == COL_LAST) begin
        col_q <= '0;
        row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
      // tail number counts only the trailing columns, restarts each frame
      if (last_o)                 tail_q <= '0;
      else if (col_q >= TAIL_COL) tail_q <= tail_q + 1'b1;
    end
  end

  assign row_o  = row_q;
  assign col_o  = col_q;
  assign tail_o = tail_q;

  p_frame_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && last_o |=> row_q == '0 && col_q == '0 && tail_q == '0);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(row_q) && $stable(col_q) && $stable(tail_q));
  p_col_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= COL_LAST && row_q <= ROW_LAST);
  p_tail_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> tail_q == TAIL_LAST);
endmodule

// File: rtl/fsq_frame_cnt.sv
module fsq_frame_cnt #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_cnt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_q == $past(cnt_q) + 1'b1);
  p_cnt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/fsq_slot_decode.sv
module fsq_slot_decode
  import fsq_pkg::*;
#(
  parameter int unsigned N_FAST    = 4,
  parameter int unsigned N_SLOW    = 25,
  parameter int unsigned COL_W     = 4,
  parameter int unsigned TAIL_W    = 5,
  parameter int unsigned CH_W      = 5,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned CNT_BYTES = 3,
  parameter logic [7:0]  MARK0     = 8'hEB,
  parameter logic [7:0]  MARK1     = 8'h90
) (
  input  logic [COL_W-1:0]  col_i,
  input  logic [TAIL_W-1:0] tail_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output slot_kind_e        kind_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [7:0]        data_o
);
  localparam int unsigned EXT_W = 8 * CNT_BYTES;

  logic [EXT_W-1:0] cnt_ext;
  assign cnt_ext = EXT_W'(cnt_i);

  always_comb begin
    kind_o = SLOT_FAST;
    chan_o = '0;
    data_o = '0;
    if (col_i < COL_W'(N_FAST)) begin
      kind_o = SLOT_FAST;
      chan_o = CH_W'(col_i);
    end else if (tail_i < TAIL_W'(N_SLOW)) begin
      kind_o = SLOT_SLOW;
      chan_o = CH_W'(N_FAST) + CH_W'(tail_i);
    end else if (tail_i < TAIL_W'(N_SLOW + 2)) begin
      kind_o = SLOT_MARK;
      data_o = (tail_i == TAIL_W'(N_SLOW)) ? MARK0 : MARK1;
    end else begin
      kind_o = SLOT_COUNT;
      // most significant byte first
      for (int b = 0; b < int'(CNT_BYTES); b++) begin
        if (tail_i == TAIL_W'(N_SLOW + 2 + b))
          data_o = cnt_ext[8*(int'(CNT_BYTES)-1-b) +: 8];
      end
    end
  end
endmodule

// File: rtl/fsq_switch_dec.sv
module fsq_switch_dec #(
  parameter int unsigned CH_W   = 5,
  parameter int unsigned SW_IN  = 16,
  parameter int unsigned NUM_SW = 2,
  parameter int unsigned SEL_W  = $clog2(SW_IN)
) (
  input  logic                           sample_i,
  input  logic [CH_W-1:0]                chan_i,
  output logic [NUM_SW-1:0]              en_o,
  output logic [NUM_SW-1:0][SEL_W-1:0]   sel_o
);
  logic [31:0] chan_ext;
  assign chan_ext = 32'(chan_i);

  for (genvar g = 0; g < int'(NUM_SW); g++) begin : g_sw
    assign en_o[g]  = sample_i && ((chan_ext / SW_IN) == 32'(g));
    assign sel_o[g] = en_o[g] ? SEL_W'(chan_ext % SW_IN) : '0;
  end
endmodule

// File: rtl/fsq_frame_seq.sv
module fsq_frame_seq
  import fsq_pkg::*;
#(
  parameter int unsigned N_FAST = 4,
  parameter int unsigned N_SLOW = 25,
  parameter int unsigned ROWS   = 6,
  parameter int unsigned COLS   = 9,
  parameter int unsigned SW_IN  = 16,
  parameter int unsigned CNT_W  = 24,
  parameter logic [7:0]  MARK0  = 8'hEB,
  parameter logic [7:0]  MARK1  = 8'h90,
  localparam int unsigned N_CH       = N_FAST + N_SLOW,
  localparam int unsigned CH_W       = $clog2(N_CH),
  localparam int unsigned ROW_W      = $clog2(ROWS),
  localparam int unsigned COL_W      = $clog2(COLS),
  localparam int unsigned SEL_W      = $clog2(SW_IN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [1:0]       kind_o,
  output logic [CH_W-1:0]  chan_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [7:0]       data_o,
  output logic             sw_a_en_o,
  output logic [SEL_W-1:0] sw_a_sel_o,
  output logic             sw_b_en_o,
  output logic [SEL_W-1:0] sw_b_sel_o,
  output logic [CNT_W-1:0] frame_cnt_o
);
  localparam int unsigned TAIL_SLOTS = ROWS * (COLS - N_FAST);
  localparam int unsigned TAIL_W     = $clog2(TAIL_SLOTS);
  localparam int unsigned CNT_BYTES  = TAIL_SLOTS - N_SLOW - 2;
  localparam int unsigned NUM_SW     = (N_CH + SW_IN - 1) / SW_IN;

  logic [TAIL_W-1:0] tail_w;
  logic              last_w;
  slot_kind_e        kind_w;
  logic              sample_w;
  logic [NUM_SW-1:0]             en_w;
  logic [NUM_SW-1:0][SEL_W-1:0]  sel_w;

  fsq_slot_ctr #(
    .ROWS(ROWS), .COLS(COLS), .N_FAST(N_FAST),
    .ROW_W(ROW_W), .COL_W(COL_W), .TAIL_W(TAIL_W)
  ) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .row_o(row_o), .col_o(col_o), .tail_o(tail_w), .last_o(last_w)
  );

  fsq_frame_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(tick_i && last_w),
    .cnt_o(frame_cnt_o)
  );

  fsq_slot_decode #(
    .N_FAST(N_FAST), .N_SLOW(N_SLOW), .COL_W(COL_W), .TAIL_W(TAIL_W),
    .CH_W(CH_W), .CNT_W(CNT_W), .CNT_BYTES(CNT_BYTES),
    .MARK0(MARK0), .MARK1(MARK1)
  ) u_dec (
    .col_i(col_o), .tail_i(tail_w), .cnt_i(frame_cnt_o),
    .kind_o(kind_w), .chan_o(chan_o), .data_o(data_o)
  );

  assign sample_w = (kind_w == SLOT_FAST) || (kind_w == SLOT_SLOW);

  fsq_switch_dec #(
    .CH_W(CH_W), .SW_IN(SW_IN), .NUM_SW(NUM_SW), .SEL_W(SEL_W)
  ) u_sw (
    .sample_i(sample_w), .chan_i(chan_o), .en_o(en_w), .sel_o(sel_w)
  );

  assign kind_o     = kind_w;
  assign sw_a_en_o  = en_w[0];
  assign sw_a_sel_o = sel_w[0];
  assign sw_b_en_o  = en_w[NUM_SW-1];
  assign sw_b_sel_o = sel_w[NUM_SW-1];

  p_one_switch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_w |-> $countones({sw_a_en_o, sw_b_en_o}) == 1);
  p_switch_a_map_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_a_en_o |-> chan_o < CH_W'(SW_IN) && CH_W'(sw_a_sel_o) == chan_o);
  p_idle_switch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_w |-> !sw_a_en_o && !sw_b_en_o && chan_o == '0);
  p_fast_cols_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_o < COL_W'(N_FAST) |-> kind_w == SLOT_FAST && chan_o == CH_W'(col_o));
  p_slow_ascend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && kind_w == SLOT_SLOW && chan_o != CH_W'(N_CH - 1)
    |=> kind_w == SLOT_FAST || chan_o == $past(chan_o) + 1'b1);
  p_count_at_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_cnt_o) |-> row_o == '0 && col_o == '0);
endmodule

// File: tb/fsq_frame_seq_tb_top.sv
module fsq_frame_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 54;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]  kind;
  logic [4:0]  chan;
  logic [2:0]  row;
  logic [3:0]  col;
  logic [7:0]  data;
  logic        ea, eb;
  logic [3:0]  sa, sb;
  logic [23:0] fcnt;

  logic [1:0]  w_kind;
  logic [4:0]  w_chan;
  logic [2:0]  w_row;
  logic [3:0]  w_col;
  logic [7:0]  w_data;
  logic        w_ea, w_eb;
  logic [3:0]  w_sa, w_sb;
  logic [1:0]  w_fcnt;

  fsq_frame_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .kind_o(kind), .chan_o(chan), .row_o(row), .col_o(col), .data_o(data),
    .sw_a_en_o(ea), .sw_a_sel_o(sa), .sw_b_en_o(eb), .sw_b_sel_o(sb),
    .frame_cnt_o(fcnt)
  );

  // narrow counter copy for the wrap check
  fsq_frame_seq #(.CNT_W(2)) dut_w_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .kind_o(w_kind), .chan_o(w_chan), .row_o(w_row), .col_o(w_col), .data_o(w_data),
    .sw_a_en_o(w_ea), .sw_a_sel_o(w_sa), .sw_b_en_o(w_eb), .sw_b_sel_o(w_sb),
    .frame_cnt_o(w_fcnt)
  );

  typedef struct packed {
    logic [5:0] slot;
    logic [3:0] req;
    logic [1:0] kind;
    logic [4:0] chan;
    logic [7:0] data;
    logic       ea;
    logic [3:0] sa;
    logic       eb;
    logic [3:0] sb;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{6'd0,  4'd1, 2'd0, 5'd0,  8'h00, 1'b1, 4'd0,  1'b0, 4'd0},
    '{6'd3,  4'd3, 2'd0, 5'd3,  8'h00, 1'b1, 4'd3,  1'b0, 4'd0},
    '{6'd4,  4'd4, 2'd1, 5'd4,  8'h00, 1'b1, 4'd4,  1'b0, 4'd0},
    '{6'd8,  4'd4, 2'd1, 5'd8,  8'h00, 1'b1, 4'd8,  1'b0, 4'd0},
    '{6'd9,  4'd3, 2'd0, 5'd0,  8'h00, 1'b1, 4'd0,  1'b0, 4'd0},
    '{6'd13, 4'd4, 2'd1, 5'd9,  8'h00, 1'b1, 4'd9,  1'b0, 4'd0},
    '{6'd22, 4'd7, 2'd1, 5'd14, 8'h00, 1'b1, 4'd14, 1'b0, 4'd0},
    '{6'd23, 4'd7, 2'd1, 5'd15, 8'h00, 1'b1, 4'd15, 1'b0, 4'd0},
    '{6'd24, 4'd7, 2'd1, 5'd16, 8'h00, 1'b0, 4'd0,  1'b1, 4'd0},
    '{6'd44, 4'd7, 2'd1, 5'd28, 8'h00, 1'b0, 4'd0,  1'b1, 4'd12},
    '{6'd48, 4'd3, 2'd0, 5'd3,  8'h00, 1'b1, 4'd3,  1'b0, 4'd0},
    '{6'd49, 4'd5, 2'd2, 5'd0,  8'hEB, 1'b0, 4'd0,  1'b0, 4'd0},
    '{6'd50, 4'd5, 2'd2, 5'd0,  8'h90, 1'b0, 4'd0,  1'b0, 4'd0},
    '{6'd51, 4'd6, 2'd3, 5'd0,  8'h00, 1'b0, 4'd0,  1'b0, 4'd0},
    '{6'd53, 4'd6, 2'd3, 5'd0,  8'h00, 1'b0, 4'd0,  1'b0, 4'd0}
  };

  int n_run = 0;
  int n_fail = 0;
  int cur = 0;
  int frame = 0;

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic adv(int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
      frame = frame + (cur + n) / SLOTS;
      cur = (cur + n) % SLOTS;
    end
  endtask

  // expected slot contents from the requirements
  task automatic model(input int s, input int f,
                       output int k, output int ch, output int d,
                       output int xa, output int xsa, output int xb, output int xsb);
    int r, c, t;
    r = s / 9; c = s % 9;
    k = 0; ch = 0; d = 0;
    if (c < 4) begin
      k = 0; ch = c;
    end else begin
      t = 5 * r + c - 4;
      if (t < 25)       begin k = 1; ch = 4 + t; end
      else if (t == 25) begin k = 2; d = 8'hEB; end
      else if (t == 26) begin k = 2; d = 8'h90; end
      else              begin k = 3; d = (f >> (8 * (29 - t))) & 255; end
    end
    xa = (k < 2 && ch < 16) ? 1 : 0;
    xb = (k < 2 && ch >= 16) ? 1 : 0;
    xsa = xa ? ch : 0;
    xsb = xb ? ch - 16 : 0;
  endtask

  task automatic check_model(int f);
    int k, ch, d, xa, xsa, xb, xsb;
    model(cur, f, k, ch, d, xa, xsa, xb, xsb);
    check("R2 row", int'(row), cur / 9);
    check("R2 col", int'(col), cur % 9);
    check(k == 0 ? "R3 kind" : (k == 1 ? "R4 kind" : "R8 kind"), int'(kind), k);
    check(k == 1 ? "R4 chan" : "R3 chan", int'(chan), ch);
    check(k == 3 ? "R6 data" : "R5 data", int'(data), d);
    check("R7 a_en", int'(ea), xa);
    check("R7 a_sel", int'(sa), xsa);
    check("R7 b_en", int'(eb), xb);
    check("R7 b_sel", int'(sb), xsb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 kind in reset", int'(kind), 0);
    check("R1 cnt in reset", int'(fcnt), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk through frame 0
    for (int i = 0; i < NV; i++) begin
      string tag;
      adv(int'(VECS[i].slot) - cur);
      tag = $sformatf("R%0d", VECS[i].req);
      check({tag, " kind"}, int'(kind), int'(VECS[i].kind));
      check({tag, " chan"}, int'(chan), int'(VECS[i].chan));
      check({tag, " data"}, int'(data), int'(VECS[i].data));
      check({tag, " a_en"}, int'(ea),   int'(VECS[i].ea));
      check({tag, " a_sel"}, int'(sa),  int'(VECS[i].sa));
      check({tag, " b_en"}, int'(eb),   int'(VECS[i].eb));
      check({tag, " b_sel"}, int'(sb),  int'(VECS[i].sb));
      check("R10 cnt frame0", int'(fcnt), 0);
    end

    // R2/R9: wrap into frame 1
    adv(SLOTS - cur);
    check("R2 wrap row", int'(row), 0);
    check("R2 wrap col", int'(col), 0);
    check("R9 cnt after frame", int'(fcnt), 1);

    // full frame 1 against model; count bytes must read 0,0,1 (R6, R10)
    for (int s = 0; s < SLOTS; s++) begin
      check_model(frame);
      check("R10 cnt stable", int'(fcnt), 1);
      adv(1);
    end
    check("R9 cnt frame2", int'(fcnt), 2);

    // R2: hold with no tick, at a marker slot (R5)
    adv(50);
    begin
      logic [7:0] d0; logic [1:0] k0; logic [3:0] c0;
      d0 = data; k0 = kind; c0 = col;
      repeat (5) @(negedge clk);
      check("R2 hold data", int'(data), int'(d0));
      check("R2 hold kind", int'(kind), int'(k0));
      check("R2 hold col", int'(col), int'(c0));
      check("R5 mark1 held", int'(data), 8'h90);
    end

    // frame 3: count bytes of the 2-bit copy, then its wrap (R6, R9)
    adv(SLOTS + 1);
    check("R6 frame", frame, 3);
    check("R6 w byte hi", int'(w_data), 0);
    adv(2);
    check("R6 w byte lo", int'(w_data), 3);
    check("R6 byte lo", int'(data), 3);
    check("R8 count no mux", int'(ea) + int'(eb), 0);
    adv(1);
    check("R9 wrap to zero", int'(w_fcnt), 0);
    check("R9 wide count", int'(fcnt), 4);
    adv(53);
    check("R6 w byte after wrap", int'(w_data), 0);
    check("R6 byte frame4", int'(data), 4);

    // R1: asynchronous reset mid-frame, held across a tick
    adv(20);
    @(negedge clk);
    rst_ni = 1'b0;
    tick = 1'b1;
    #1;
    check("R1 row", int'(row), 0);
    check("R1 col", int'(col), 0);
    check("R1 cnt", int'(fcnt), 0);
    @(negedge clk);
    tick = 1'b0;
    check("R1 kind", int'(kind), 0);
    check("R1 chan", int'(chan), 0);
    check("R1 a_en", int'(ea), 1);
    check("R1 b_en", int'(eb), 0);
    check("R1 col held", int'(col), 0);
    rst_ni = 1'b1;
    cur = 0; frame = 0;
    adv(3);
    check("R3 after reset", int'(chan), 3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule